// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block holds the two status bytes of a serial NOR flash device and enforces the rules that decide whether a status write may land. A command front end hands it one decoded command per clock: read of either status byte, one of two write-enable flavours, a two-byte status write, or nothing. A separate power-event input models a power-down or reset of the device. The write-protect pin is sampled on the same edge as the command.

A two-bit lock field (lock bit 0 in byte 1, lock bit 1 in byte 2) selects one of four protection levels: free, pin-gated, blocked until the next power event, and blocked for good. The permanent level exists only in the layout with a 3-bit block-protect field; in the 4-bit layout any lock bit 1 value is cleared by a power event. A write armed by the ordinary write enable is stored non-volatile and holds busy high for a programmable time. A write armed by the volatile enable changes only the working copy, with no busy period, and is lost at the next power event.

Top module: `sreg_guard`

## Requirements
- R1: cmd_op codes are 0 idle, 1 read byte 1, 2 read byte 2, 3 write enable, 4 volatile write enable, 5 status write. A read raises rd_valid for the single cycle after the command with the byte in rd_data. Byte 1 reads as busy in bit 0, write-enable latch in bit 1 and stored bits in 7:2. Byte 2 reads its stored bits with bits 2 and 7 always 0.
- R2: After reset both bytes read 0x00, busy is low and rd_valid is low.
- R3: Write enable (code 3) and volatile write enable (code 4) set the latch, seen as bit 1 of byte 1.
- R4: A status write with the latch clear changes neither byte and leaves the latch clear.
- R5: With lock bits (byte 2 bit 0, byte 1 bit 7) at 00 a status write is accepted when the latch is set; at 01 it is accepted only if wp_pin is also 1.
- R6: With lock bit 1 (byte 2 bit 0) set, every status write is rejected.
- R7: A write accepted after code 3 is kept non-volatile and busy is high for exactly WRITE_TIME cycles from the cycle after the command; while busy, only reads act.
- R8: A write accepted after code 4 raises no busy, and a later power event restores the stored non-volatile values.
- R9: An accepted status write clears the latch; cmd_wdata[7:0] goes to byte 1, cmd_wdata[15:8] to byte 2.
- R10: Bits 1:0 of byte 1 and bits 2 and 7 of byte 2 cannot be written.
- R11: A power event clears the latch and busy and clears lock bit 1 in both copies, except as R12 states; it has priority over a command in the same cycle.
- R12: With BP_WIDTH 3, a stored lock value of 11 survives a power event; with BP_WIDTH 4 it does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Decoded command code, see R1 |
| cmd_wdata | input | 16 | Status write data, low byte to byte 1 |
| wp_pin | input | 1 | Write-protect pin level |
| pwr_event | input | 1 | Power-down or device reset event |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Status byte returned by a read |
| busy | output | 1 | Non-volatile write in progress |

## Verification
Read data and rd_valid are due one rising edge after the command, and they show the state that held before that edge. Busy rises on the edge that accepts a non-volatile write and falls WRITE_TIME edges later, while a power event drops it on the next edge. The bench drives every input on the falling edge, steps a reference model of both layout variants by one command, and compares the outputs on the following falling edge. A comparison therefore always lands exactly one register stage after its stimulus.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_READ_S1 = 3'd1,
        OP_READ_S2 = 3'd2,
        OP_WEN     = 3'd3,
        OP_WEN_VOL = 3'd4,
        OP_WRITE_S = 3'd5
    } op_e;

    localparam logic [7:0] S1_WMASK = 8'hFC;
    localparam logic [7:0] S2_WMASK = 8'h7B;

    typedef struct packed {
        logic [7:0] act1;
        logic [7:0] act2;
        logic [7:0] nv1;
        logic [7:0] nv2;
        logic       wel;
        logic       vol;
        logic       rd_valid;
        logic [7:0] rd_data;
    } state_t;
endpackage

// File: rtl/sreg_lock_eval.sv
module sreg_lock_eval #(
    parameter int BP_WIDTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock0,
    input  logic lock1,
    input  logic nv_lock0,
    input  logic nv_lock1,
    input  logic wel,
    input  logic wp_pin,
    input  logic busy,
    output logic permit,
    output logic keep_lock
);
    always_comb begin
        permit    = !busy && wel && !lock1 && (!lock0 || wp_pin);
        keep_lock = (BP_WIDTH == 3) && nv_lock0 && nv_lock1;
    end

    // R6
    lock1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock1 |-> !permit);

    // R5
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock0 && !wp_pin) |-> !permit);
endmodule

// File: rtl/sreg_wr_timer.sv
module sreg_wr_timer #(
    parameter int WRITE_TIME = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic busy
);
    localparam int CNT_W = $clog2(WRITE_TIME + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (start)
            cnt_d = CNT_W'(WRITE_TIME);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WRITE_TIME));

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> busy);
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_pkg::*;
#(
    parameter int BP_WIDTH   = 3,
    parameter int WRITE_TIME = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cmd_op,
    input  logic [15:0] cmd_wdata,
    input  logic        wp_pin,
    input  logic        pwr_event,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        busy
);
    state_t st_d, st_q;
    op_e    op;
    logic   permit, keep_lock;
    logic   tmr_start, tmr_clear;
    logic [7:0] view1, view2;

    assign op    = op_e'(cmd_op);
    assign view1 = {st_q.act1[7:2], st_q.wel, busy};
    assign view2 = st_q.act2 & S2_WMASK;

    sreg_lock_eval #(.BP_WIDTH(BP_WIDTH)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock0    (st_q.act1[7]),
        .lock1    (st_q.act2[0]),
        .nv_lock0 (st_q.nv1[7]),
        .nv_lock1 (st_q.nv2[0]),
        .wel      (st_q.wel),
        .wp_pin   (wp_pin),
        .busy     (busy),
        .permit   (permit),
        .keep_lock(keep_lock)
    );

    sreg_wr_timer #(.WRITE_TIME(WRITE_TIME)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .clear(tmr_clear),
        .busy (busy)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        tmr_start     = 1'b0;
        tmr_clear     = 1'b0;
        if (pwr_event) begin
            st_d.act1 = st_q.nv1;
            st_d.act2 = st_q.nv2;
            if (!keep_lock) begin
                st_d.act2[0] = 1'b0;
                st_d.nv2[0]  = 1'b0;
            end
            st_d.wel  = 1'b0;
            st_d.vol  = 1'b0;
            tmr_clear = 1'b1;
        end else begin
            case (op)
                OP_READ_S1: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = view1;
                end
                OP_READ_S2: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = view2;
                end
                OP_WEN: if (!busy) begin
                    st_d.wel = 1'b1;
                    st_d.vol = 1'b0;
                end
                OP_WEN_VOL: if (!busy) begin
                    st_d.wel = 1'b1;
                    st_d.vol = 1'b1;
                end
                OP_WRITE_S: if (permit) begin
                    st_d.act1 = (st_q.act1 & ~S1_WMASK) | (cmd_wdata[7:0] & S1_WMASK);
                    st_d.act2 = (st_q.act2 & ~S2_WMASK) | (cmd_wdata[15:8] & S2_WMASK);
                    if (!st_q.vol) begin
                        st_d.nv1  = st_d.act1;
                        st_d.nv2  = st_d.act2;
                        tmr_start = 1'b1;
                    end
                    st_d.wel = 1'b0;
                    st_d.vol = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE_S && !st_q.wel && !pwr_event)
        |=> ($stable(st_q.act1) && $stable(st_q.act2) && !st_q.wel));

    // R9
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE_S && permit && !pwr_event) |=> !st_q.wel);

    // R11
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_event |=> (!st_q.wel && !busy));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwr_event && op != OP_READ_S1 && op != OP_READ_S2)
        |=> ($stable(st_q.wel) && $stable(st_q.act1) && $stable(st_q.act2)));

    // R1
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_event || (op != OP_READ_S1 && op != OP_READ_S2)) |=> !rd_valid);
endmodule

// File: tb/tb_sreg_guard.sv
module tb_sreg_guard;
    localparam int WT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_wdata = '0;
    logic        wp_pin = 1'b0;
    logic        pwr_event = 1'b0;
    logic        rv [2];
    logic [7:0]  rdat [2];
    logic        bz [2];

    int checks = 0;
    int errors = 0;

    logic [7:0] m_a1 [2], m_a2 [2], m_n1 [2], m_n2 [2];
    logic       m_wel [2], m_vol [2];
    int         m_cnt [2];

    always #5 clk = ~clk;

    sreg_guard #(.BP_WIDTH(3), .WRITE_TIME(WT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .wp_pin(wp_pin), .pwr_event(pwr_event),
        .rd_valid(rv[0]), .rd_data(rdat[0]), .busy(bz[0]));

    sreg_guard #(.BP_WIDTH(4), .WRITE_TIME(WT)) dut_b (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .wp_pin(wp_pin), .pwr_event(pwr_event),
        .rd_valid(rv[1]), .rd_data(rdat[1]), .busy(bz[1]));

    function automatic logic [7:0] view1(input int v);
        return {m_a1[v][7:2], m_wel[v], m_cnt[v] != 0};
    endfunction

    function automatic logic [7:0] view2(input int v);
        return m_a2[v] & 8'h7B;
    endfunction

    task automatic check(input string tag, input int v, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s variant%0d: actual %02h expected %02h at %0t", tag, v, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_a1[v] = '0; m_a2[v] = '0; m_n1[v] = '0; m_n2[v] = '0;
            m_wel[v] = 1'b0; m_vol[v] = 1'b0; m_cnt[v] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_op = '0; pwr_event = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < 2; v++) begin
            check("R2", v, {7'd0, rv[v]}, 8'h00);
            check("R2", v, {7'd0, bz[v]}, 8'h00);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [15:0] d, input logic wp,
                        input logic pw, input string tag);
        logic       ev [2];
        logic [7:0] ed [2];
        cmd_op = op; cmd_wdata = d; wp_pin = wp; pwr_event = pw;
        for (int v = 0; v < 2; v++) begin
            logic busy_m;
            logic ok;
            busy_m = (m_cnt[v] != 0);
            ok = !busy_m && m_wel[v] && !m_a2[v][0] && (!m_a1[v][7] || wp);
            ev[v] = 1'b0;
            ed[v] = 8'h00;
            if (pw) begin
                m_a1[v] = m_n1[v];
                m_a2[v] = m_n2[v];
                if (!(v == 0 && m_n1[v][7] && m_n2[v][0])) begin
                    m_a2[v][0] = 1'b0;
                    m_n2[v][0] = 1'b0;
                end
                m_wel[v] = 1'b0; m_vol[v] = 1'b0; m_cnt[v] = 0;
            end else begin
                if (m_cnt[v] > 0) m_cnt[v]--;
                case (op)
                    3'd1: begin ev[v] = 1'b1; ed[v] = {m_a1[v][7:2], m_wel[v], busy_m}; end
                    3'd2: begin ev[v] = 1'b1; ed[v] = view2(v); end
                    3'd3: if (!busy_m) begin m_wel[v] = 1'b1; m_vol[v] = 1'b0; end
                    3'd4: if (!busy_m) begin m_wel[v] = 1'b1; m_vol[v] = 1'b1; end
                    3'd5: if (ok) begin
                        m_a1[v] = d[7:0] & 8'hFC;
                        m_a2[v] = d[15:8] & 8'h7B;
                        if (!m_vol[v]) begin
                            m_n1[v] = m_a1[v]; m_n2[v] = m_a2[v]; m_cnt[v] = WT;
                        end
                        m_wel[v] = 1'b0; m_vol[v] = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int v = 0; v < 2; v++) begin
            check(tag, v, {7'd0, rv[v]}, {7'd0, ev[v]});
            if (ev[v]) check(tag, v, rdat[v], ed[v]);
            check(tag, v, {7'd0, bz[v]}, {7'd0, m_cnt[v] != 0});
        end
        cmd_op = '0; pwr_event = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(3'd0, 16'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(10 * 60000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        do_reset();
        // R2 reset contents
        step(3'd1, 16'h0, 1'b0, 1'b0, "R2");
        step(3'd2, 16'h0, 1'b0, 1'b0, "R2");
        // R4 write without latch
        step(3'd5, 16'hFE7F, 1'b1, 1'b0, "R4");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R4");
        // R3 latch visible
        step(3'd3, 16'h0, 1'b0, 1'b0, "R3");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R3");
        check("R3", 0, rdat[0], 8'h02);
        // R7 R9 R10 non-volatile write, fixed bits dropped
        step(3'd5, 16'hFE7F, 1'b0, 1'b0, "R7");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R9");
        check("R9", 0, rdat[0], 8'h7D);
        step(3'd2, 16'h0, 1'b0, 1'b0, "R10");
        check("R10", 0, rdat[0], 8'h7A);
        step(3'd3, 16'h0, 1'b0, 1'b0, "R7");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R7");
        idle(WT, "R7");
        // R5 pin-gated lock
        step(3'd3, 16'h0, 1'b0, 1'b0, "R5");
        step(3'd5, 16'h0080, 1'b0, 1'b0, "R5");
        idle(WT + 1, "R7");
        step(3'd3, 16'h0, 1'b0, 1'b0, "R5");
        step(3'd5, 16'h0084, 1'b0, 1'b0, "R5");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R5");
        step(3'd5, 16'h0084, 1'b1, 1'b0, "R5");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R5");
        idle(WT, "R7");
        // R8 R6 volatile lock 11, then power event
        step(3'd4, 16'h0, 1'b0, 1'b0, "R8");
        step(3'd5, 16'h0180, 1'b1, 1'b0, "R8");
        step(3'd2, 16'h0, 1'b0, 1'b0, "R8");
        step(3'd3, 16'h0, 1'b0, 1'b0, "R6");
        step(3'd5, 16'h0000, 1'b1, 1'b0, "R6");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R6");
        step(3'd1, 16'h0, 1'b0, 1'b1, "R11");
        step(3'd1, 16'h0, 1'b0, 1'b0, "R8");
        check("R8", 0, rdat[0], 8'h84);
        step(3'd2, 16'h0, 1'b0, 1'b0, "R8");
        // R12 stored lock 11
        step(3'd3, 16'h0, 1'b0, 1'b0, "R12");
        step(3'd5, 16'h0180, 1'b1, 1'b0, "R12");
        idle(3, "R7");
        step(3'd3, 16'h0, 1'b0, 1'b1, "R11");
        step(3'd2, 16'h0, 1'b0, 1'b0, "R12");
        check("R12", 0, rdat[0], 8'h01);
        check("R12", 1, rdat[1], 8'h00);
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic pw;
            string tg;
            op = 3'($urandom % 6);
            pw = (($urandom % 60) == 0);
            case (op)
                3'd1, 3'd2: tg = "R1";
                3'd3, 3'd4: tg = "R3";
                3'd5:       tg = "R5";
                default:    tg = "R7";
            endcase
            if (pw) tg = "R11";
            if (i == 1500) do_reset();
            step(op, 16'($urandom), 1'($urandom), pw, tg);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule